// File: doc/BRIEF.md
# Oversampling Serial Word Receiver

This block turns an asynchronous serial line into parallel words. It first passes the incoming line through a two-stage synchroniser. It then watches for the high-to-low edge that opens a frame and times everything after that edge in units of an external oversampling strobe. There are sixteen strobes per bit time. The start bit is checked again at the half-bit point, so a short low pulse is thrown away. Each later bit is sampled in the middle of its bit time.

A frame is made of these bits, in order:
- one low start bit;
- the data bits, least significant bit first;
- an optional parity bit;
- one high stop bit.

Parity is either even or odd. With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity, they hold an odd number. Two static inputs choose whether a parity bit is present and which sense it uses.

Each finished word goes into a single holding register. The register keeps the word's parity and framing results next to it. An overrun flag is raised if a new word arrives before the previous one has been acknowledged. A one-cycle read strobe empties the holding register.

Top module: `serial_word_rx`

## Requirements
- R1: After reset, `rx_valid`, `err_parity`, `err_frame` and `err_overrun` are all 0.
- R2: A low pulse that has ended by the 8th oversampling strobe after the falling edge produces no word. The receiver then goes back to waiting for a new falling edge.
- R3: Data bit i is sampled 24 + 16·i strobes after the falling edge. Bits are assembled least significant bit first, so the first data bit on the line becomes `rx_data[0]`. Every completed frame sets `rx_valid`.
- R4: With `parity_en`=1 and `parity_odd`=0, the bit after the data is the even-parity bit. If the data plus that bit hold an odd number of ones, `err_parity` is set with the word. Otherwise it stays 0.
- R5: With `parity_en`=1 and `parity_odd`=1, the data plus the parity bit must hold an odd number of ones. If they do not, `err_parity` is set with the word.
- R6: With `parity_en`=0, the stop bit directly follows the last data bit, and `err_parity` is 0 for every word.
- R7: If the stop bit is sampled as 0, `err_frame` is set. The word is still delivered with `rx_valid`=1.
- R8: If a word completes while `rx_valid` is already 1 and no `rd_ack` arrives in the same cycle, `err_overrun` is set. The holding register then holds the newest word.
- R9: A one-cycle `rd_ack` with no word completing in that cycle clears `rx_valid`, `err_parity`, `err_frame` and `err_overrun` on the next clock edge.
- R10: Once the stop bit has been sampled, a falling edge that arrives while the line is still inside the nominal stop-bit time starts a new frame, and that frame is received.
- R11: Frames whose bit time is 3% longer or 3% shorter than sixteen strobes are received without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line | input | 1 | Asynchronous serial input; idles high |
| os_tick | input | 1 | Oversampling strobe, sixteen per bit time |
| parity_en | input | 1 | 1: a parity bit follows the data |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_ack | input | 1 | Read strobe; empties the holding register |
| rx_data | output | DATA_BITS | Word held in the holding register |
| rx_valid | output | 1 | The holding register holds an unread word |
| err_parity | output | 1 | The held word had a parity mismatch |
| err_frame | output | 1 | The held word's stop bit was sampled low |
| err_overrun | output | 1 | An unread word was overwritten |

## Verification
The hardest state to reach from the ports is a start edge that lands inside the stop bit of the previous frame. The stimulus shortens one frame's stop bit to about two thirds of a bit time and starts the next frame straight away. Both frames must then come out, and the second is caught through the overrun flag it raises. The glitch path and the baud-rate tolerance are reached in a similar way: the bench drives line timing at clock resolution against a strobe that divides the clock by four, which lets a pulse end before the half-bit check and lets bit times stretch or shrink by 3%.

// File: rtl/serial_word_rx_pkg.sv
// Package: shared types for the serial word receiver.
// Assumes nothing beyond the standard data types.
package serial_word_rx_pkg;

    // Frame walker states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
// Module: rx_line_sync
// Brings the asynchronous serial line into the clock domain through two
// flops and flags the high-to-low transitions of the synchronised line.
// Assumes the line idles high, so all stages reset to 1.
module rx_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_s,
    output logic line_fall
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Purpose: two-flop synchroniser plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line_s    = sync_q;
    assign line_fall = prev_q & ~sync_q;

endmodule

// File: rtl/rx_frame_fsm.sv
// Module: rx_frame_fsm
// Walks one serial frame. It counts oversampling strobes from the falling
// edge, confirms the start bit at the half-bit point, samples every later
// bit at its centre, and emits a one-cycle completion pulse together with
// the word, its parity result and its stop-bit result.
// Assumes DATA_BITS >= 2, OVERSAMPLE even and >= 4, and a format
// configuration that does not change while a frame is in flight.
module rx_frame_fsm
    import serial_word_rx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_s,
    input  logic                 line_fall,
    input  logic                 os_tick,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    output logic                 word_done,
    output logic [DATA_BITS-1:0] word_data,
    output logic                 word_perr,
    output logic                 word_ferr
);

    localparam int PH_W = $clog2(OVERSAMPLE);
    localparam int BI_W = $clog2(DATA_BITS);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(OVERSAMPLE / 2 - 1);
    localparam logic [PH_W-1:0] PH_FULL = PH_W'(OVERSAMPLE - 1);
    localparam logic [BI_W-1:0] BI_LAST = BI_W'(DATA_BITS - 1);

    rx_state_e            state;
    logic [PH_W-1:0]      phase;
    logic [BI_W-1:0]      bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_rx;
    logic                 done_q;
    logic                 perr_q;
    logic                 ferr_q;
    logic                 at_centre;
    logic                 par_expect;

    // Purpose: high when the current strobe lands on a bit centre.
    always_comb begin
        at_centre = os_tick && (phase == PH_FULL);
    end

    // Purpose: parity bit the transmitter should have sent for the word.
    always_comb begin
        par_expect = (^shreg) ^ parity_odd;
    end

    // Purpose: frame state, strobe phase, bit index and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_rx  <= 1'b0;
            done_q  <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (line_fall) begin
                        state <= ST_START;
                        phase <= '0;
                    end
                end
                ST_START: begin
                    if (os_tick) begin
                        if (phase == PH_HALF) begin
                            phase   <= '0;
                            bit_idx <= '0;
                            state   <= line_s ? ST_IDLE : ST_DATA;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (at_centre) begin
                        phase <= '0;
                        shreg <= {line_s, shreg[DATA_BITS-1:1]};
                        if (bit_idx == BI_LAST) begin
                            state <= parity_en ? ST_PAR : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else if (os_tick) begin
                        phase <= phase + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (at_centre) begin
                        phase  <= '0;
                        par_rx <= line_s;
                        state  <= ST_STOP;
                    end else if (os_tick) begin
                        phase <= phase + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (at_centre) begin
                        phase  <= '0;
                        done_q <= 1'b1;
                        ferr_q <= ~line_s;
                        perr_q <= parity_en && (par_rx != par_expect);
                        state  <= ST_IDLE;
                    end else if (os_tick) begin
                        phase <= phase + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign word_done = done_q;
    assign word_data = shreg;
    assign word_perr = perr_q;
    assign word_ferr = ferr_q;

    // R2: a start bit that is high again at the half-bit check is dropped.
    p_glitch_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && os_tick && phase == PH_HALF && line_s)
        |=> (state == ST_IDLE && !word_done));

    // R3: every completed frame gives exactly a one-cycle pulse.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

    // R6: with parity off, no parity error can be reported.
    p_no_perr_without_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !parity_en) |-> !word_perr);

    // R10: after the stop sample the walker is ready for the next edge.
    p_ready_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> (state == ST_IDLE));

endmodule

// File: rtl/rx_hold_reg.sv
// Module: rx_hold_reg
// Single-entry holding register for received words and their flags.
// A completing word always replaces the held one; the overrun flag records
// that an unread word was lost. A read strobe empties the register.
// Assumes word_done is a one-cycle pulse.
module rx_hold_reg #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_done,
    input  logic [DATA_BITS-1:0] word_data,
    input  logic                 word_perr,
    input  logic                 word_ferr,
    input  logic                 rd_ack,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 err_parity,
    output logic                 err_frame,
    output logic                 err_overrun
);

    // Purpose: load a new word, track overrun, clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end else if (word_done) begin
            rx_data     <= word_data;
            rx_valid    <= 1'b1;
            err_parity  <= word_perr;
            err_frame   <= word_ferr;
            err_overrun <= (rx_valid | err_overrun) & ~rd_ack;
        end else if (rd_ack) begin
            rx_valid    <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end
    end

    // R8: an overrun is only reported alongside a held word.
    p_overrun_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> rx_valid);

    // R8: a word landing on an unread word, without a read, flags overrun.
    p_overrun_on_collision_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && rx_valid && !rd_ack) |=> err_overrun);

    // R9: a read with no new word empties the register and clears flags.
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !word_done) |=> (!rx_valid && !err_overrun && !err_parity && !err_frame));

    // R3: a completed frame always leaves a valid word behind.
    p_load_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> rx_valid);

endmodule

// File: rtl/serial_word_rx.sv
// Module: serial_word_rx (top)
// Oversampling serial receiver: synchroniser, frame walker and holding
// register. Assumes os_tick arrives OVERSAMPLE times per nominal bit time
// and lasts one clock cycle.
module serial_word_rx #(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    input  logic                 os_tick,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    input  logic                 rd_ack,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 err_parity,
    output logic                 err_frame,
    output logic                 err_overrun
);

    logic                 line_s;
    logic                 line_fall;
    logic                 word_done;
    logic [DATA_BITS-1:0] word_data;
    logic                 word_perr;
    logic                 word_ferr;

    rx_line_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (rx_line),
        .line_s     (line_s),
        .line_fall  (line_fall)
    );

    rx_frame_fsm #(
        .DATA_BITS  (DATA_BITS),
        .OVERSAMPLE (OVERSAMPLE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_s     (line_s),
        .line_fall  (line_fall),
        .os_tick    (os_tick),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .word_done  (word_done),
        .word_data  (word_data),
        .word_perr  (word_perr),
        .word_ferr  (word_ferr)
    );

    rx_hold_reg #(
        .DATA_BITS (DATA_BITS)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_done   (word_done),
        .word_data   (word_data),
        .word_perr   (word_perr),
        .word_ferr   (word_ferr),
        .rd_ack      (rd_ack),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_overrun (err_overrun)
    );

    // R1: nothing is reported in the first cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!rx_valid && !err_parity && !err_frame && !err_overrun));

endmodule

// File: tb/serial_word_rx_bench.sv
// Bench for serial_word_rx: 200 MHz clock, strobe every 4 clocks (64 clocks
// per nominal bit), table-driven frames followed by directed corner cases.
module serial_word_rx_bench;

    localparam int NB  = 8;
    localparam int PER = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_line = 1'b1;
    logic          os_tick = 1'b0;
    logic          parity_en = 1'b0;
    logic          parity_odd = 1'b0;
    logic          rd_ack = 1'b0;
    logic [NB-1:0] rx_data;
    logic          rx_valid;
    logic          err_parity;
    logic          err_frame;
    logic          err_overrun;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    logic [1:0] tick_div = 2'd0;

    always #2.5 clk = ~clk;

    // Strobe generator, updated away from the active edge.
    always @(negedge clk) begin
        tick_div <= tick_div + 2'd1;
        os_tick  <= (tick_div == 2'd3);
    end

    serial_word_rx #(.DATA_BITS(NB), .OVERSAMPLE(16)) u_serial_word_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_line     (rx_line),
        .os_tick     (os_tick),
        .parity_en   (parity_en),
        .parity_odd  (parity_odd),
        .rd_ack      (rd_ack),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_overrun (err_overrun)
    );

    // Vector: {pen, podd, bad_par, stop_val, data[7:0]}
    localparam logic [11:0] VEC [10] = '{
        {1'b0, 1'b0, 1'b0, 1'b1, 8'hA5},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h00},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'hFF},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h01},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h3C},
        {1'b1, 1'b0, 1'b1, 1'b1, 8'h81},
        {1'b1, 1'b1, 1'b0, 1'b1, 8'h7E},
        {1'b1, 1'b1, 1'b1, 1'b1, 8'h01},
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h55},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'hC3}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input logic [NB-1:0] d, input bit bad_par,
                              input bit stop_val, input int per, input int stop_len);
        rx_line = 1'b0;
        repeat (per) @(negedge clk);
        for (int i = 0; i < NB; i++) begin
            rx_line = d[i];
            repeat (per) @(negedge clk);
        end
        if (parity_en) begin
            rx_line = (^d) ^ parity_odd ^ bad_par;
            repeat (per) @(negedge clk);
        end
        rx_line = stop_val;
        repeat (stop_len) @(negedge clk);
        rx_line = 1'b1;
    endtask

    task automatic pulse_ack();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 valid", {31'd0, rx_valid}, 32'd0);
        check("R1 flags", {29'd0, err_parity, err_frame, err_overrun}, 32'd0);
        repeat (PER) @(negedge clk);

        // R3 R4 R5 R6 R7 R9: table of frames
        for (int k = 0; k < 10; k++) begin
            logic [11:0] v;
            v = VEC[k];
            parity_en  = v[11];
            parity_odd = v[10];
            send_frame(v[7:0], v[9], v[8], PER, PER);
            repeat (PER) @(negedge clk);
            check($sformatf("R3 valid vec%0d", k), {31'd0, rx_valid}, 32'd1);
            check($sformatf("R3 data vec%0d", k), {24'd0, rx_data}, {24'd0, v[7:0]});
            check($sformatf("R4/R5/R6 parity vec%0d", k), {31'd0, err_parity},
                  {31'd0, v[11] & v[9]});
            check($sformatf("R7 frame vec%0d", k), {31'd0, err_frame}, {31'd0, ~v[8]});
            check($sformatf("R8 no overrun vec%0d", k), {31'd0, err_overrun}, 32'd0);
            pulse_ack();
            check($sformatf("R9 cleared vec%0d", k),
                  {28'd0, rx_valid, err_parity, err_frame, err_overrun}, 32'd0);
        end

        // R2: short low pulse is rejected, then a real frame still arrives
        parity_en = 1'b0;
        parity_odd = 1'b0;
        rx_line = 1'b0;
        repeat (12) @(negedge clk);
        rx_line = 1'b1;
        repeat (12 * PER) @(negedge clk);
        check("R2 glitch gives no word", {31'd0, rx_valid}, 32'd0);
        send_frame(8'h96, 1'b0, 1'b1, PER, PER);
        repeat (PER) @(negedge clk);
        check("R2 frame after glitch", {23'd0, rx_valid, rx_data}, {23'd0, 1'b1, 8'h96});
        pulse_ack();

        // R10 R8: next start inside the stop bit, no read in between
        send_frame(8'h3A, 1'b0, 1'b1, PER, 44);
        send_frame(8'hC5, 1'b0, 1'b1, PER, PER);
        repeat (PER) @(negedge clk);
        check("R10 second frame data", {24'd0, rx_data}, 32'h0000_00C5);
        check("R8 overrun set", {31'd0, err_overrun}, 32'd1);
        check("R10 no frame error", {31'd0, err_frame}, 32'd0);
        pulse_ack();
        check("R9 overrun cleared", {30'd0, rx_valid, err_overrun}, 32'd0);

        // R11: bit time 3% short and 3% long
        send_frame(8'h6B, 1'b0, 1'b1, 62, 62);
        repeat (PER) @(negedge clk);
        check("R11 fast data", {22'd0, rx_valid, err_frame, rx_data}, {22'd0, 2'b10, 8'h6B});
        pulse_ack();
        send_frame(8'hD4, 1'b0, 1'b1, 66, 66);
        repeat (PER) @(negedge clk);
        check("R11 slow data", {22'd0, rx_valid, err_frame, rx_data}, {22'd0, 2'b10, 8'hD4});
        pulse_ack();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule